// File: doc/BRIEF.md
# Routed Interrupt Controller with Software Set and Clear

This block collects interrupt requests from a set of sources and delivers them to a small number of interrupt lines that go to a processor. Every source has a 64-bit configuration word. The word holds an enable flag, a route field that picks the output line, and a field naming the target hardware thread. A single pending word records which sources are waiting to be serviced. Software reads the pending word and changes it through two write-only views. Writing to one view raises the bits that are 1 in the written word. Writing to the other view drops them. Bits written as 0 have no effect in either view.

The lower sources have hardware inputs. Each of these is captured either as a level or as a rising edge, chosen per source by a parameter. The upper sources have no hardware input. Software raises them through the set view, which lets them serve as inter-processor signals: source 16+t targets thread t, normally routed to the last line. Each output line is a registered OR over every source that is pending, enabled and routed to that line.

Top module: `irq_route_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every configuration word reads 0, the pending word reads 0 and every output line is low.
- R2: The configuration word of source i sits at byte address i*8. A read returns exactly the 64 bits last written, including the thread field in bits [30:8].
- R3: Bit 31 of a configuration word enables its source. A source whose enable bit is 0 never drives an output line.
- R4: Bits [3:0] of a configuration word select output line 0 to 4. A value of 5 or more routes the source to no line. Line k goes high one clock after some source is pending, enabled and routed to k, and goes low one clock after no such source is left.
- R5: A write to address 0x108 sets every pending bit whose written bit is 1 and leaves every other pending bit as it was.
- R6: A write to address 0x110 clears every pending bit whose written bit is 1 and leaves every other pending bit as it was.
- R7: Address 0x100 reads the pending word, with bit i holding source i. Reads of 0x108 and 0x110 return the same word. A read of an unmapped address returns 0.
- R8: An edge-captured hardware source (by default sources 4 to 15) sets its pending bit on a rising edge of its input. Holding the input high does not set the bit again after it has been cleared.
- R9: A level-captured hardware source (by default sources 0 to 3) sets its pending bit on every clock in which its input is high, so a clear has no lasting effect while the input stays high.
- R10: When a hardware capture and a clear write hit the same bit in the same clock, the bit ends up set.
- R11: Sources 16 to 31 have no hardware input, and no hardware input changes their pending bits. A set write of bit 16+t, with that source routed to line 4, raises line 4.
- R12: With no register write and every hardware input low, the pending word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 9 | Byte address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| hw_irq | input | 16 | Hardware request inputs of sources 0 to 15 |
| irq_out | output | 5 | Interrupt lines toward the processor; line 4 is kept for inter-processor use |

## Verification
The properties assume that the register port carries at most one access per clock and that its address is stable and word aligned whenever a check reads `reg_rdata`. The hold and clear-all properties assume that every hardware input is low in the cycle they start from. Level-captured inputs would otherwise keep setting pending bits. The stimulus drives hardware inputs only inside the steps that test capture and returns them to 0 afterwards. It drives all port inputs a nanosecond after the rising edge, so each write commits at exactly one edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int unsigned REG_W      = 64;
   localparam int unsigned WORD_BYTES = 8;

   // Control words follow the configuration region, in this order.
   localparam int unsigned OFS_PEND = 0;
   localparam int unsigned OFS_SET  = 8;
   localparam int unsigned OFS_CLR  = 16;
   localparam int unsigned CTRL_WORDS = 3;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_CFG,
      RGN_PEND,
      RGN_SET,
      RGN_CLR
   } rgn_e;

   function automatic int unsigned ctrl_base(input int unsigned nsrc);
      return nsrc * WORD_BYTES;
   endfunction

   function automatic int unsigned addr_bits(input int unsigned nsrc);
      return $clog2((nsrc + CTRL_WORDS) * WORD_BYTES);
   endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output rgn_e              rgn,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_base(NUM_SRC));
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ctrl_base(NUM_SRC) + OFS_PEND);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ctrl_base(NUM_SRC) + OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ctrl_base(NUM_SRC) + OFS_CLR);

   if (ADDR_W < IDX_W + 3) begin : g_bad_addr
      $error("irq_addr_dec: address too narrow for index");
   end

   always_comb begin
      rgn = RGN_NONE;
      idx = addr[IDX_W+2:3];
      if (addr[2:0] == 3'b000) begin
         if (addr < A_CTRL)       rgn = RGN_CFG;
         else if (addr == A_PEND) rgn = RGN_PEND;
         else if (addr == A_SET)  rgn = RGN_SET;
         else if (addr == A_CLR)  rgn = RGN_CLR;
      end
   end

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned ROUTE_W = 4,
   parameter int unsigned EN_BIT  = 31,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 idx,
   input  logic [REG_W-1:0]                 wdata,
   output logic [REG_W-1:0]                 rd_word,
   output logic [NUM_SRC-1:0]               en_vec,
   output logic [NUM_SRC-1:0][ROUTE_W-1:0]  route
);

   logic [REG_W-1:0] cfg_mem [NUM_SRC];

   if (EN_BIT >= REG_W || EN_BIT < ROUTE_W) begin : g_bad_en
      $error("irq_cfg_bank: enable bit overlaps route field or word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) cfg_mem[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (idx == IDX_W'(i)) cfg_mem[i] <= wdata;
         end
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_fields
      assign en_vec[g] = cfg_mem[g][EN_BIT];
      assign route[g]  = cfg_mem[g][ROUTE_W-1:0];
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (idx == IDX_W'(i)) rd_word = cfg_mem[i];
      end
   end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned       NUM_SRC    = 32,
   parameter int unsigned       NUM_HW     = 16,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'('hF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_HW-1:0]  hw_in,
   input  logic [NUM_SRC-1:0] set_mask,
   input  logic [NUM_SRC-1:0] clr_mask,
   output logic [NUM_SRC-1:0] pend
);

   logic [NUM_SRC-1:0] hw_hit;

   if (NUM_HW == 0 || NUM_HW > NUM_SRC) begin : g_bad_hw
      $error("irq_pend_bank: hardware source count out of range");
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g >= NUM_HW) begin : g_soft
         assign hw_hit[g] = 1'b0;
      end else if (LEVEL_MASK[g]) begin : g_level
         assign hw_hit[g] = hw_in[g];
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= hw_in[g];
         end
         assign hw_hit[g] = hw_in[g] & ~prev_q;
      end
   end

   // Any set source (software or hardware) wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_mask) | set_mask | hw_hit;
   end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_OUT = 5,
   parameter int unsigned ROUTE_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              pend,
   input  logic [NUM_SRC-1:0]              en_vec,
   input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route,
   output logic [NUM_OUT-1:0]              lines
);

   logic [NUM_SRC-1:0] live;

   if (NUM_OUT > (1 << ROUTE_W)) begin : g_bad_out
      $error("irq_route_merge: route field cannot name every line");
   end

   assign live = pend & en_vec;

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
      logic [NUM_SRC-1:0] sel;
      always_comb begin
         for (int i = 0; i < NUM_SRC; i++) begin
            sel[i] = live[i] && (route[i] == ROUTE_W'(k));
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lines[k] <= 1'b0;
         else        lines[k] <= |sel;
      end
   end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int unsigned        NUM_SRC    = 32,
   parameter int unsigned        NUM_OUT    = 5,
   parameter int unsigned        SOFT_BASE  = 16,
   parameter int unsigned        ROUTE_W    = 4,
   parameter int unsigned        EN_BIT     = 31,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'('hF),
   localparam int unsigned       ADDR_W     = addr_bits(NUM_SRC),
   localparam int unsigned       IDX_W      = $clog2(NUM_SRC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic [SOFT_BASE-1:0] hw_irq,
   output logic [NUM_OUT-1:0]   irq_out
);

   if (NUM_SRC < 2 || NUM_SRC > REG_W) begin : g_bad_src
      $error("irq_route_ctrl: source count must fit one pending word");
   end

   rgn_e                            rgn;
   logic [IDX_W-1:0]                idx;
   logic [REG_W-1:0]                cfg_rd;
   logic [NUM_SRC-1:0]              en_vec;
   logic [NUM_SRC-1:0][ROUTE_W-1:0] route;
   logic [NUM_SRC-1:0]              pend_q;
   logic [NUM_SRC-1:0]              set_mask;
   logic [NUM_SRC-1:0]              clr_mask;

   irq_addr_dec #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_dec (
      .addr(reg_addr), .rgn(rgn), .idx(idx)
   );

   irq_cfg_bank #(
      .NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W), .EN_BIT(EN_BIT), .IDX_W(IDX_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we && rgn == RGN_CFG), .idx(idx), .wdata(reg_wdata),
      .rd_word(cfg_rd), .en_vec(en_vec), .route(route)
   );

   assign set_mask = (reg_we && rgn == RGN_SET) ? reg_wdata[NUM_SRC-1:0] : '0;
   assign clr_mask = (reg_we && rgn == RGN_CLR) ? reg_wdata[NUM_SRC-1:0] : '0;

   irq_pend_bank #(
      .NUM_SRC(NUM_SRC), .NUM_HW(SOFT_BASE), .LEVEL_MASK(LEVEL_MASK)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .hw_in(hw_irq),
      .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend_q)
   );

   irq_route_merge #(
      .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .ROUTE_W(ROUTE_W)
   ) u_merge (
      .clk(clk), .rst_n(rst_n), .pend(pend_q), .en_vec(en_vec),
      .route(route), .lines(irq_out)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (rgn)
         RGN_CFG:                    reg_rdata = cfg_rd;
         RGN_PEND, RGN_SET, RGN_CLR: reg_rdata[NUM_SRC-1:0] = pend_q;
         default:                    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_OUT = 5,
   parameter int unsigned NUM_HW  = 16,
   parameter int unsigned ADDR_W  = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [NUM_SRC-1:0] wlow,
   input logic [NUM_SRC-1:0] rlow,
   input logic [NUM_HW-1:0]  hw_irq,
   input logic [NUM_OUT-1:0] irq_out,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] en_vec
);

   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ctrl_base(NUM_SRC) + OFS_PEND);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ctrl_base(NUM_SRC) + OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ctrl_base(NUM_SRC) + OFS_CLR);

   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec == '0) |=> (irq_out == '0));

   a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_SET) |=> ((pend & $past(wlow)) == $past(wlow)));

   a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CLR && wlow == '1 && hw_irq == '0) |=> (pend == '0));

   a_r7_pend_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_PEND) |-> (rlow == pend));

   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && hw_irq == '0) |=> $stable(pend));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_HW(SOFT_BASE), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .wlow(reg_wdata[NUM_SRC-1:0]), .rlow(reg_rdata[NUM_SRC-1:0]),
   .hw_irq(hw_irq), .irq_out(irq_out), .pend(pend_q), .en_vec(en_vec)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

   localparam logic [8:0] A_PEND = 9'h100;
   localparam logic [8:0] A_SET  = 9'h108;
   localparam logic [8:0] A_CLR  = 9'h110;
   localparam logic [63:0] EN    = 64'h8000_0000;

   typedef struct {
      bit          is_out;
      logic [63:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [15:0] hw_irq = '0;
   logic [4:0]  irq_out;

   int   n_tests = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   irq_route_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq),
      .irq_out(irq_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [8:0] a, input logic [63:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic exp_rd(input logic [8:0] a, input logic [63:0] e, input string tag);
      item_t it;
      reg_addr = a;
      it.is_out = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      step();
   endtask

   task automatic exp_out(input logic [4:0] e, input string tag);
      item_t it;
      it.is_out = 1'b1; it.exp = {59'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      step();
   endtask

   // Monitor: compares the queued expectation away from the rising edge.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            act = it.is_out ? {59'b0, irq_out} : reg_rdata;
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      exp_rd(9'h000, 64'h0, "R1 cfg0");
      exp_rd(9'h0F8, 64'h0, "R1 cfg31");
      exp_rd(A_PEND, 64'h0, "R1 pend");
      exp_out(5'b0, "R1 lines");

      // R2: exact readback including thread field
      wr(9'h028, 64'hDEAD_BEEF_8ABC_DE03);
      exp_rd(9'h028, 64'hDEAD_BEEF_8ABC_DE03, "R2 cfg5");
      wr(9'h0A0, 64'h0000_0000_5A5A_5A02);
      exp_rd(9'h0A0, 64'h0000_0000_5A5A_5A02, "R2 cfg20 thread");
      exp_rd(9'h028, 64'hDEAD_BEEF_8ABC_DE03, "R2 cfg5 kept");
      wr(9'h028, 64'h0);
      wr(9'h0A0, 64'h0);

      // R5, R7: software set and read views
      wr(A_SET, 64'hF0F0_0000);
      exp_rd(A_PEND, 64'hF0F0_0000, "R5 set");
      exp_rd(A_SET, 64'hF0F0_0000, "R7 read set view");
      exp_rd(A_CLR, 64'hF0F0_0000, "R7 read clear view");
      exp_rd(9'h118, 64'h0, "R7 unmapped");
      exp_out(5'b0, "R3 all disabled");

      // R4: routing
      wr(9'h0A0, EN | 64'd2);
      step();
      exp_out(5'b00100, "R4 line2");
      wr(9'h0A8, EN | 64'd4);
      step();
      exp_out(5'b10100, "R4 line4");
      wr(9'h0B0, EN | 64'd7);
      step();
      exp_out(5'b10100, "R4 route7 none");
      wr(9'h0B8, EN | 64'd5);
      step();
      exp_out(5'b10100, "R4 route5 none");
      wr(9'h0A0, 64'd2);
      step();
      exp_out(5'b10000, "R3 disabled src20");

      // R6: clear
      wr(A_CLR, 64'h0020_0000);
      exp_rd(A_PEND, 64'hF0D0_0000, "R6 clear one");
      exp_out(5'b00000, "R6 line4 drops");
      wr(A_CLR, 64'hFFFF_FFFF);
      exp_rd(A_PEND, 64'h0, "R6 clear all");
      wr(9'h0A8, 64'h0);
      wr(9'h0B0, 64'h0);
      wr(9'h0B8, 64'h0);

      // R11: inter-processor signal for thread 1
      wr(9'h088, EN | 64'h104);
      wr(A_SET, 64'h0002_0000);
      step();
      exp_out(5'b10000, "R11 ipi line4");
      wr(A_CLR, 64'h0002_0000);
      step();
      exp_out(5'b00000, "R11 ipi cleared");
      wr(9'h088, 64'h0);

      // R8: edge capture on source 8
      wr(9'h040, EN);
      hw_irq[8] = 1'b1;
      step();
      exp_rd(A_PEND, 64'h100, "R8 edge sets");
      exp_out(5'b00001, "R8 line0");
      wr(A_CLR, 64'h100);
      exp_rd(A_PEND, 64'h0, "R8 held high no reset");

      // R10: edge and clear in the same cycle
      hw_irq[8] = 1'b0;
      step();
      hw_irq[8] = 1'b1;
      wr(A_CLR, 64'h100);
      exp_rd(A_PEND, 64'h100, "R10 set wins");
      hw_irq[8] = 1'b0;
      wr(A_CLR, 64'h100);
      exp_rd(A_PEND, 64'h0, "R10 cleared after");
      wr(9'h040, 64'h0);

      // R9: level capture on source 2
      hw_irq[2] = 1'b1;
      step();
      exp_rd(A_PEND, 64'h4, "R9 level sets");
      wr(A_CLR, 64'h4);
      exp_rd(A_PEND, 64'h4, "R9 clear undone");
      hw_irq[2] = 1'b0;
      wr(A_CLR, 64'h4);
      exp_rd(A_PEND, 64'h0, "R9 clear after low");

      // R11: hardware cannot reach soft sources
      hw_irq = 16'hFFFF;
      step();
      step();
      exp_rd(A_PEND, 64'h0000_FFFF, "R11 soft untouched");
      hw_irq = 16'h0;
      wr(A_CLR, 64'hFFFF_FFFF);
      exp_rd(A_PEND, 64'h0, "R12 cleared");
      step();
      exp_rd(A_PEND, 64'h0, "R12 idle hold");

      // R1: reset in the middle of activity
      wr(9'h000, EN);
      wr(A_SET, 64'h1);
      step();
      exp_out(5'b00001, "R1 pre-reset line0");
      rst_n = 1'b0;
      #1;
      exp_rd(9'h000, 64'h0, "R1 cfg cleared");
      exp_rd(A_PEND, 64'h0, "R1 pend cleared");
      exp_out(5'b0, "R1 lines cleared");
      rst_n = 1'b1;
      step();
      exp_out(5'b0, "R1 after release");

      step();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule